// File: doc/BRIEF.md
# IPv4 Header Check and TTL Decrement Unit

This block sits in a packet pipeline and takes a frame-level stream of 32-bit words. Each word is qualified by a data-enable, the first word of a frame carries a start-of-frame flag and the last carries an end-of-frame flag. Every frame holds an IPv4 packet whose header begins on the start-of-frame word. The unit keeps the header words in a small buffer until the last of them has arrived. By then the version, the header length, the ones'-complement header checksum and the time-to-live are all known.

If the header is acceptable, the unit forwards the whole packet with the TTL lowered by one and the checksum patched to match. It raises a one-cycle start-of-payload strobe on the first word after the header. If the header fails, the buffered words are discarded and the rest of the frame is swallowed up to its end-of-frame. No partial packet ever reaches the output. Output words leave in arrival order, with a fixed delay of IHL cycles while the input is continuous.

Top module: `ip_hdr_ttl_unit`

## Requirements
- R1: A frame is dropped entirely (no output word) when its first word has a version field (bits 31:28) other than 4, or a header-length field IHL (bits 27:24, in 32-bit words) below 5.
- R2: A frame is dropped entirely when the ones'-complement sum of all 16-bit halves of its IHL header words, checksum field included, is not 0xFFFF.
- R3: A frame whose TTL (bits 31:24 of header word 2, counting from 0) is 0 or 1 is dropped entirely.
- R4: In a forwarded frame, the TTL byte of header word 2 leaves reduced by one, and the protocol byte (bits 23:16) is unchanged.
- R5: In a forwarded frame, the checksum field (bits 15:0 of header word 2) leaves as the received value plus 0x0100, with any carry out of bit 15 added back in at bit 0.
- R6: A forwarded frame leaves with all its words in order and every other word unchanged. The output start-of-frame flag is on the first word and the end-of-frame flag is on the last. No flag is high without output data-enable, and the outputs are idle after reset.
- R7: The start-of-payload output is high for exactly one cycle, together with the output word at offset IHL from the frame start. It stays low for a frame that ends on its last header word.
- R8: A frame whose end-of-frame arrives before its last header word is dropped. Words accepted while no frame is open (no preceding start-of-frame) are ignored.
- R9: No word of a frame is output before its last header word has been accepted, so the decision always precedes the release.
- R10: Under back-to-back traffic with headers of up to 15 words, the buffer never holds 16 or more entries, and the released-but-unsent count never exceeds the occupancy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_data | input | 32 | Input stream word |
| in_en | input | 1 | Input word valid |
| in_sof | input | 1 | Input word is the first of a frame |
| in_eof | input | 1 | Input word is the last of a frame |
| out_data | output | 32 | Output stream word |
| out_en | output | 1 | Output word valid |
| out_sof | output | 1 | Output word is the first of a frame |
| out_eof | output | 1 | Output word is the last of a frame |
| out_sop | output | 1 | Output word is the first payload word |

## Verification
The header-length sweep from 5 to 15 words, crossed with payloads of zero to three words, separates the correct decision point and strobe position from off-by-one errors in the header counter. The version and header-length sweeps, the single-bit checksum corruptions and the TTL values 0, 1, 2, 3 and 255 each isolate one drop cause, with good frames interleaved so that a faulty flush shows up as a damaged neighbour. Checksums forced near 0xFFxx tell an end-around carry apart from a plain 16-bit add. Truncated frames, stray words, gapped input and back-to-back 15-word headers probe the buffer rewind and the release accounting.

// File: rtl/ip_hdr_pkg.sv
package ip_hdr_pkg;

  localparam logic [3:0] IPV4_VER = 4'd4;
  localparam logic [3:0] MIN_IHL  = 4'd5;

  typedef struct packed {
    logic [31:0] data;
    logic        sof;
    logic        eof;
    logic        sop;
  } ent_t;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_PASS, ST_DROP} rx_st_t;

  // Ones'-complement accumulate of both halves of a word.
  function automatic logic [15:0] oc_add_word(input logic [15:0] acc, input logic [31:0] w);
    logic [17:0] t;
    logic [16:0] u;
    t = {2'b00, acc} + {2'b00, w[31:16]} + {2'b00, w[15:0]};
    u = {1'b0, t[15:0]} + {15'd0, t[17:16]};
    return u[15:0] + {15'd0, u[16]};
  endfunction

  // Checksum patch for a TTL lowered by one.
  function automatic logic [15:0] oc_ttl_patch(input logic [15:0] c);
    logic [16:0] t;
    t = {1'b0, c} + 17'h00100;
    return t[15:0] + {15'd0, t[16]};
  endfunction

endpackage

// File: rtl/ip_hdr_fifo.sv
module ip_hdr_fifo
  import ip_hdr_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  ent_t          wdata,
  input  logic          rewind,
  input  logic [AW:0]   rewind_to,
  input  logic          pop,
  output ent_t          rdata,
  output logic [AW:0]   wr_ptr,
  output logic [AW:0]   count
);
  localparam int DEPTH = 1 << AW;

  ent_t        mem [DEPTH];
  logic [AW:0] rd_ptr, wr_base, wr_ptr_n, rd_ptr_n;

  always_comb begin
    wr_base  = rewind ? rewind_to : wr_ptr;
    wr_ptr_n = push ? wr_base + (AW+1)'(1) : wr_base;
    rd_ptr_n = pop ? rd_ptr + (AW+1)'(1) : rd_ptr;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_base[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
    end
  end

  assign rdata = mem[rd_ptr[AW-1:0]];
  assign count = wr_ptr - rd_ptr;

endmodule

// File: rtl/ip_hdr_ctl.sv
module ip_hdr_ctl
  import ip_hdr_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   in_data,
  input  logic          in_en,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [AW:0]   wr_ptr,
  output logic          push,
  output ent_t          wdata,
  output logic          rewind,
  output logic [AW:0]   rewind_to,
  output logic [AW:0]   rel_add
);
  rx_st_t      st, st_n;
  logic [3:0]  hcnt, hcnt_n, ihl, ihl_n;
  logic [15:0] acc, acc_n, acc_w;
  logic        ttl_ok, ttl_ok_n, ttl_w, sop_pend, sop_pend_n, last;
  logic [AW:0] base, base_n;

  always_comb begin
    st_n       = st;
    hcnt_n     = hcnt;
    ihl_n      = ihl;
    acc_n      = acc;
    ttl_ok_n   = ttl_ok;
    base_n     = base;
    sop_pend_n = sop_pend;
    push       = 1'b0;
    rewind     = 1'b0;
    rewind_to  = base;
    rel_add    = '0;
    wdata      = '{data: in_data, sof: 1'b0, eof: in_eof, sop: 1'b0};
    acc_w      = oc_add_word(acc, in_data);
    last       = (hcnt == ihl - 4'd1);
    ttl_w      = (hcnt == 4'd2) ? (in_data[31:24] > 8'd1) : ttl_ok;
    if (in_en) begin
      if (in_sof) begin
        rewind     = (st == ST_HDR);
        sop_pend_n = 1'b0;
        if (in_data[31:28] == IPV4_VER && in_data[27:24] >= MIN_IHL && !in_eof) begin
          push      = 1'b1;
          wdata.sof = 1'b1;
          st_n      = ST_HDR;
          hcnt_n    = 4'd1;
          ihl_n     = in_data[27:24];
          acc_n     = oc_add_word(16'h0000, in_data);
          ttl_ok_n  = 1'b0;
          base_n    = (st == ST_HDR) ? base : wr_ptr;
        end else begin
          st_n = in_eof ? ST_IDLE : ST_DROP;
        end
      end else begin
        case (st)
          ST_HDR: begin
            acc_n    = acc_w;
            ttl_ok_n = ttl_w;
            if (hcnt == 4'd2)
              wdata.data = {in_data[31:24] - 8'd1, in_data[23:16], oc_ttl_patch(in_data[15:0])};
            if (last) begin
              if (acc_w == 16'hFFFF && ttl_w) begin
                push       = 1'b1;
                rel_add    = (AW+1)'(hcnt) + (AW+1)'(1);
                st_n       = in_eof ? ST_IDLE : ST_PASS;
                sop_pend_n = !in_eof;
              end else begin
                rewind = 1'b1;
                st_n   = in_eof ? ST_IDLE : ST_DROP;
              end
            end else if (in_eof) begin
              rewind = 1'b1;
              st_n   = ST_IDLE;
            end else begin
              push   = 1'b1;
              hcnt_n = hcnt + 4'd1;
            end
          end
          ST_PASS: begin
            push       = 1'b1;
            wdata.sop  = sop_pend;
            sop_pend_n = 1'b0;
            rel_add    = (AW+1)'(1);
            if (in_eof) st_n = ST_IDLE;
          end
          ST_DROP: begin
            if (in_eof) st_n = ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      hcnt     <= '0;
      ihl      <= '0;
      acc      <= '0;
      ttl_ok   <= 1'b0;
      sop_pend <= 1'b0;
      base     <= '0;
    end else begin
      st       <= st_n;
      hcnt     <= hcnt_n;
      ihl      <= ihl_n;
      acc      <= acc_n;
      ttl_ok   <= ttl_ok_n;
      sop_pend <= sop_pend_n;
      base     <= base_n;
    end
  end

endmodule

// File: rtl/ip_hdr_ttl_unit.sv
module ip_hdr_ttl_unit
  import ip_hdr_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] in_data,
  input  logic        in_en,
  input  logic        in_sof,
  input  logic        in_eof,
  output logic [31:0] out_data,
  output logic        out_en,
  output logic        out_sof,
  output logic        out_eof,
  output logic        out_sop
);
  logic [1:0]  rst_sync;
  logic        rst_i_n;
  logic        push, rewind, pop;
  ent_t        wdata, head;
  logic [AW:0] rewind_to, rel_add, wr_ptr, fifo_cnt, released, released_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  ip_hdr_ctl #(.AW(AW)) u_ctl (
    .clk(clk), .rst_n(rst_i_n),
    .in_data(in_data), .in_en(in_en), .in_sof(in_sof), .in_eof(in_eof),
    .wr_ptr(wr_ptr), .push(push), .wdata(wdata),
    .rewind(rewind), .rewind_to(rewind_to), .rel_add(rel_add)
  );

  ip_hdr_fifo #(.AW(AW)) u_fifo (
    .clk(clk), .rst_n(rst_i_n), .push(push), .wdata(wdata),
    .rewind(rewind), .rewind_to(rewind_to), .pop(pop),
    .rdata(head), .wr_ptr(wr_ptr), .count(fifo_cnt)
  );

  always_comb begin
    pop        = (released != '0);
    released_n = released - (AW+1)'(pop) + rel_add;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      released <= '0;
      out_en   <= 1'b0;
      out_sof  <= 1'b0;
      out_eof  <= 1'b0;
      out_sop  <= 1'b0;
      out_data <= '0;
    end else begin
      released <= released_n;
      out_en   <= pop;
      out_sof  <= pop & head.sof;
      out_eof  <= pop & head.eof;
      out_sop  <= pop & head.sop;
      if (pop) out_data <= head.data;
    end
  end

endmodule

// File: rtl/ip_hdr_ttl_chk.sv
module ip_hdr_ttl_chk #(
  parameter int AW = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        out_en,
  input logic        out_sof,
  input logic        out_eof,
  input logic        out_sop,
  input logic [AW:0] released,
  input logic [AW:0] fifo_cnt
);
  localparam int DEPTH = 1 << AW;

  assert_flags_need_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof || out_eof || out_sop) |-> out_en);

  assert_sof_not_repeated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |=> !out_sof);

  assert_sop_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |=> !out_sop);

  assert_sop_after_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> !out_sof);

  assert_occupancy_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt < (AW+1)'(DEPTH));

  assert_release_in_buffer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    released <= fifo_cnt);

endmodule

bind ip_hdr_ttl_unit ip_hdr_ttl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_i_n),
  .out_en(out_en), .out_sof(out_sof), .out_eof(out_eof), .out_sop(out_sop),
  .released(released), .fifo_cnt(fifo_cnt)
);

// File: tb/ip_hdr_ttl_unit_tb.sv
module ip_hdr_ttl_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] in_data, out_data;
  logic        in_en, in_sof, in_eof, out_en, out_sof, out_eof, out_sop;

  always #10 clk = ~clk;

  ip_hdr_ttl_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_en(in_en),
    .in_sof(in_sof), .in_eof(in_eof), .out_data(out_data), .out_en(out_en),
    .out_sof(out_sof), .out_eof(out_eof), .out_sop(out_sop)
  );

  int nchk = 0, nerr = 0, cyc = 0, seed = 1;
  logic [34:0] exp_q[$], got_q[$];
  logic [31:0] fw[$];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++; nchk++;
      $display("FAIL watchdog (R6) actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n && out_en) got_q.push_back({out_data, out_sof, out_eof, out_sop});
    if (rst_n && !out_en && (out_sof || out_eof || out_sop)) begin
      nchk++; nerr++;
      $display("FAIL R6 flag without enable actual=%b%b%b expected=000", out_sof, out_eof, out_sop);
    end
  end

  function automatic logic [15:0] bsum(input logic [15:0] a, input logic [15:0] b);
    int t;
    t = int'(a) + int'(b);
    if (t > 65535) t -= 65535;
    return 16'(t);
  endfunction

  function automatic logic [15:0] hsum(input int n);
    logic [15:0] s = 16'h0;
    for (int i = 0; i < n; i++) s = bsum(bsum(s, fw[i][31:16]), fw[i][15:0]);
    return s;
  endfunction

  task automatic check(input string req, input logic ok, input logic [63:0] act, input logic [63:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // ck_target != 0 steers the identification field so the checksum lands on that value
  task automatic frame(input string req, input logic [3:0] ver, input logic [3:0] ihl,
                       input logic [7:0] ttl, input int plen, input bit corrupt,
                       input int keep, input int gap, input logic [15:0] ck_target, input bit hold);
    int nh, total;
    bit pass;
    logic [31:0] w;
    logic [15:0] s;
    nh = (ihl < 4'd5) ? 5 : int'(ihl);
    fw.delete();
    fw.push_back({ver, ihl, 8'h00, 16'((nh + plen) * 4)});
    fw.push_back({16'(seed * 37), 16'h4000});
    fw.push_back({ttl, 8'd17, 16'h0000});
    fw.push_back(32'h0A000001 + seed);
    fw.push_back(32'hC0A80000 + seed * 3);
    for (int i = 5; i < nh; i++) fw.push_back(32'h01020304 * i + seed);
    if (ck_target != 16'h0) begin
      w = fw[1]; w[31:16] = 16'h0; fw[1] = w;
      s = hsum(nh);
      w = fw[1]; w[31:16] = bsum(~ck_target, ~s); fw[1] = w;
    end
    s = hsum(nh);
    w = fw[2]; w[15:0] = ~s; fw[2] = w;
    if (corrupt) begin w = fw[3]; w[5] = ~w[5]; fw[3] = w; end
    for (int i = 0; i < plen; i++) fw.push_back(32'hA5000000 + (seed << 8) + i);
    seed++;
    total = (keep > 0) ? keep : fw.size();
    pass = (ver == 4'd4) && (ihl >= 4'd5) && !corrupt && (ttl > 8'd1) && (total >= nh);
    if (pass)
      for (int i = 0; i < total; i++) begin
        w = fw[i];
        if (i == 2) w = {w[31:24] - 8'd1, w[23:16], bsum(w[15:0], 16'h0100)};
        exp_q.push_back({w, i == 0, i == total - 1, (i == nh) && (total > nh)});
      end
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      if (hold && i >= 1 && i <= nh) check({req, " output during header"}, out_en == 1'b0, 64'(out_en), 64'd0);
      in_en = 1'b1; in_sof = (i == 0); in_eof = (i == total - 1); in_data = fw[i];
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_en = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      end
    end
    @(negedge clk);
    in_en = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic stray(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_en = 1'b1; in_sof = 1'b0; in_eof = (i == n - 1); in_data = 32'h45000000 + i;
    end
    @(negedge clk);
    in_en = 1'b0; in_eof = 1'b0;
  endtask

  task automatic compare(input string req);
    repeat (40) @(negedge clk);
    check({req, " word count"}, got_q.size() == exp_q.size(), 64'(got_q.size()), 64'(exp_q.size()));
    if (got_q.size() == exp_q.size())
      for (int i = 0; i < exp_q.size(); i++)
        check({req, " word"}, got_q[i] == exp_q[i], 64'(got_q[i]), 64'(exp_q[i]));
    got_q.delete();
    exp_q.delete();
  endtask

  initial begin
    rst_n = 1'b0; in_en = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 reset outputs idle", {out_en, out_sof, out_eof, out_sop} == 4'b0,
          64'({out_en, out_sof, out_eof, out_sop}), 64'd0);

    // R4 R5 R6 R7: header length sweep crossed with payload length, back to back
    for (int h = 5; h <= 15; h++)
      for (int p = 0; p <= 3; p++) frame("R6", 4'd4, 4'(h), 8'd64, p, 0, 0, 0, 16'h0, 0);
    compare("R6");

    // R5: checksums near the top of the range force the end-around carry
    frame("R5", 4'd4, 4'd5, 8'd9, 1, 0, 0, 0, 16'hFF00, 0);
    frame("R5", 4'd4, 4'd7, 8'd9, 2, 0, 0, 0, 16'hFF80, 0);
    frame("R5", 4'd4, 4'd5, 8'd9, 0, 0, 0, 0, 16'hFFFE, 0);
    frame("R4", 4'd4, 4'd6, 8'd255, 1, 0, 0, 1, 16'h00FF, 0);
    compare("R5");

    // R1: version sweep and header length sweep
    for (int v = 0; v < 16; v++) frame("R1", 4'(v), 4'd5, 8'd20, 2, 0, 0, 0, 16'h0, 0);
    for (int h = 0; h < 16; h++) frame("R1", 4'd4, 4'(h), 8'd20, 1, 0, 0, 0, 16'h0, 0);
    compare("R1");

    // R2: corrupted headers interleaved with good ones
    for (int h = 5; h <= 15; h += 2) begin
      frame("R2", 4'd4, 4'(h), 8'd30, 2, 1, 0, 0, 16'h0, 0);
      frame("R2", 4'd4, 4'(h), 8'd30, 1, 0, 0, 0, 16'h0, 0);
    end
    compare("R2");

    // R3: TTL boundary values
    for (int t = 0; t < 4; t++) frame("R3", 4'd4, 4'd5, 8'(t), 1, 0, 0, 0, 16'h0, 0);
    frame("R3", 4'd4, 4'd9, 8'd1, 0, 0, 0, 0, 16'h0, 0);
    frame("R3", 4'd4, 4'd9, 8'd255, 0, 0, 0, 0, 16'h0, 0);
    compare("R3");

    // R8: truncated headers, stray words, end exactly on last header word
    frame("R8", 4'd4, 4'd6, 8'd40, 2, 0, 3, 0, 16'h0, 0);
    frame("R8", 4'd4, 4'd6, 8'd40, 2, 0, 1, 0, 16'h0, 0);
    stray(4);
    frame("R8", 4'd4, 4'd6, 8'd40, 2, 0, 6, 0, 16'h0, 0);
    frame("R8", 4'd4, 4'd15, 8'd40, 1, 0, 14, 0, 16'h0, 0);
    stray(2);
    frame("R8", 4'd4, 4'd5, 8'd40, 1, 0, 0, 0, 16'h0, 0);
    compare("R8");

    // R7: payload start strobe at both header length extremes
    frame("R7", 4'd4, 4'd5, 8'd50, 1, 0, 0, 0, 16'h0, 0);
    frame("R7", 4'd4, 4'd15, 8'd50, 1, 0, 0, 0, 16'h0, 0);
    frame("R7", 4'd4, 4'd15, 8'd50, 0, 0, 0, 0, 16'h0, 0);
    compare("R7");

    // R9: nothing leaves before the last header word is taken
    frame("R9", 4'd4, 4'd6, 8'd60, 2, 0, 0, 0, 16'h0, 1);
    compare("R9");
    frame("R9", 4'd4, 4'd15, 8'd60, 1, 0, 0, 0, 16'h0, 1);
    compare("R9");

    // R10: long headers back to back, with and without input gaps
    for (int k = 0; k < 6; k++) frame("R10", 4'd4, 4'd15, 8'd70, k % 3, k == 2, 0, k % 2, 16'h0, 0);
    compare("R10");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule